// File: doc/BRIEF.md
# Paged Ethernet Controller Register Bank

This block is the byte-wide host register interface of a small Ethernet controller. The host reads and writes through a 4-bit offset. Offset 0 is always the command register. The other fifteen offsets are banked: bits 7:6 of the command register choose which of up to four register pages they reach. Page 0 holds the buffer, transmit and remote-transfer setup registers, the interrupt status and the interrupt mask. Page 1 holds the station address bytes, the current receive page and the multicast filter bytes. Page 2 reads back the page 0 setup registers that cannot be read on page 0.

The block keeps an interrupt status byte that other parts of the controller set through event pulses, and that the host clears by writing ones. It combines the status with a mask to drive a level interrupt. A transmit command raises a request toward an external sender. The request carries the start address and the byte count. When the sender acknowledges, the block records a good transmit status, raises the transmit-done interrupt bit and gives a one-cycle completion strobe.

Top module: `nic_regfile`

## Requirements
- R1: After reset the command register reads 0x22, the status reads 0x80 (reset-status bit 7), the mask is 0x00, irq_o is low, and tx_req_o and tx_done_o are low.
- R2: Offset 0 reads and writes the command register on every page. The command fields are: bit 0 stop, bit 1 start, bit 2 transmit, bits 5:3 remote-transfer command, bits 7:6 page select. A new page select takes effect from the cycle after the write.
- R3: irq_o is high exactly when (status AND mask AND 0x7F) is nonzero. Status bit 7 never raises it.
- R4: A write on page 0 at offset 7 clears each status bit 0..6 whose data bit is 1. Bit 7 is not affected. An event arriving in the same cycle as the clear keeps its bit set.
- R5: A pulse on evt_i[k] (k = 0..6) sets status bit k on the next cycle.
- R6: A command write with bit 0 equal to 0 clears status bit 7.
- R7: A command write with a nonzero bits 5:3, while the remote byte count {page 0 offset 11, offset 10} is zero, sets status bit 6. The bit is not set when the count is nonzero.
- R8: Writing 1 to command bit 2 raises tx_req_o on the next cycle. While it is high, tx_addr_o is {page 0 offset 4, 8'h00} and tx_len_o is {offset 6, offset 5}. The request stays high until tx_ack_i, and command writes cannot drop it.
- R9: In the cycle after tx_ack_i is accepted, all of the following hold:
  - tx_req_o and command bit 2 are 0;
  - tx_done_o is high for exactly one cycle;
  - the transmit status (page 0 offset 4 read) is 0x01;
  - status bit 1 is set.
- R10: Page 1 offsets 1..6 (station address), 7 (current receive page) and 8..15 (multicast filter) are read/write bytes.
- R11: The page 0 writes at offsets 1, 2, 4, 12, 13, 14 and 15 are read back on page 2 at the same offsets. Offset 15 is the interrupt mask. Writes on page 2 are ignored.
- R12: With page select 3, writes to offsets 1..15 are ignored and reads return 0x00. Page 0 returns data only at offsets 3, 4, 7, 8 and 9. Page 2 returns data only at offsets 1, 2, 4 and 12..15. Every other read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for addr_i on the current page (combinational) |
| evt_i | input | 7 | Status event pulses, bit k sets status bit k |
| irq_o | output | 1 | Level interrupt |
| tx_req_o | output | 1 | Transmit request to sender |
| tx_addr_o | output | 16 | Transmit start address |
| tx_len_o | output | 16 | Transmit byte count |
| tx_ack_i | input | 1 | Sender completion acknowledge |
| tx_done_o | output | 1 | One-cycle transmit completion strobe |

## Verification
A wrong page select shows up on the next read of a banked offset. A data value from the wrong page, or a non-zero value from an unmapped offset, appears on rdata_o in that same cycle. A status bit held in the wrong state changes irq_o one cycle after the event or write that should have set or cleared it, once the mask bit is enabled. A broken transmit handshake shows as tx_req_o dropping early, or staying high after the acknowledge, or as a missing or doubled tx_done_o. The reference model compares all of these on every cycle, so such an error is reported within one cycle.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
  localparam int DW        = 8;
  localparam int OFS_W     = 4;
  localparam int N_OFS     = 1 << OFS_W;
  localparam int EVT_W     = DW - 1;
  localparam int AW        = 2 * DW;

  localparam logic [DW-1:0] CMD_RST = 8'h22;
  localparam logic [DW-1:0] ISR_RST = 8'h80;
  localparam logic [DW-1:0] TSR_OK  = 8'h01;

  localparam int CMD_STOP = 0;
  localparam int CMD_TX   = 2;
  localparam int DMA_LSB  = 3;
  localparam int DMA_W    = 3;
  localparam int PG_LSB   = 6;

  localparam int ISR_TX   = 1;
  localparam int ISR_DMA  = 6;
  localparam int ISR_RSTB = 7;

  // page 0 byte registers stored in the shared array (7 = status, 15 = mask elsewhere)
  localparam logic [N_OFS-1:0] P0_WMASK = 16'h7F7E;

  typedef enum logic [1:0] {PG_0 = 2'd0, PG_1 = 2'd1, PG_2 = 2'd2, PG_3 = 2'd3} page_e;
endpackage

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [EVT_W-1:0] clr_i,
  input  logic             rs_clr_i,
  input  logic             imr_we_i,
  input  logic [DW-1:0]    imr_i,
  output logic [DW-1:0]    isr_o,
  output logic [DW-1:0]    imr_o,
  output logic             irq_o
);
  logic [DW-1:0] isr_q, imr_q;
  logic [EVT_W-1:0] clr_eff;

  assign clr_eff = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= ISR_RST;
      imr_q <= '0;
    end else begin
      // set after clear: a concurrent event is not lost
      isr_q[EVT_W-1:0] <= (isr_q[EVT_W-1:0] & ~clr_eff) | set_i;
      isr_q[ISR_RSTB]  <= isr_q[ISR_RSTB] & ~rs_clr_i;
      if (imr_we_i) imr_q <= imr_i;
    end
  end

  assign irq_o = |(isr_q[EVT_W-1:0] & imr_q[EVT_W-1:0]);
  assign isr_o = isr_q;
  assign imr_o = imr_q;

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ((clr_i & ~set_i) != '0)) |=> ((isr_q[EVT_W-1:0] & $past(clr_i & ~set_i)) == '0)); // R4
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((isr_q[EVT_W-1:0] & $past(set_i)) == $past(set_i))); // R5
  AST_TOP_BIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_q[EVT_W-1:0] == '0) |-> !irq_o); // R3
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_reg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tx_ack_i,
  output logic [DW-1:0] cmd_o,
  output logic          tx_req_o,
  output logic          tx_fire_o,
  output logic          tx_done_o,
  output logic [DW-1:0] tsr_o
);
  logic [DW-1:0] cmd_q, cmd_d, tsr_q;
  logic          done_q;

  assign tx_fire_o = cmd_q[CMD_TX] & tx_ack_i;

  always_comb begin
    cmd_d = we_i ? wdata_i : cmd_q;
    // transmit bit: set only from idle, cleared only by the acknowledge
    cmd_d[CMD_TX] = (cmd_q[CMD_TX] & ~tx_fire_o) | (we_i & wdata_i[CMD_TX] & ~cmd_q[CMD_TX]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_RST;
      tsr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      done_q <= tx_fire_o;
      if (tx_fire_o) tsr_q <= TSR_OK;
    end
  end

  assign cmd_o     = cmd_q;
  assign tx_req_o  = cmd_q[CMD_TX];
  assign tx_done_o = done_q;
  assign tsr_o     = tsr_q;

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && !tx_ack_i) |=> tx_req_o); // R8
  AST_TX_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && tx_ack_i) |=> (!tx_req_o && tx_done_o)); // R9
  AST_TX_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (tsr_o == TSR_OK)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o); // R9
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [EVT_W-1:0] evt_i,
  output logic             irq_o,
  output logic             tx_req_o,
  output logic [AW-1:0]    tx_addr_o,
  output logic [AW-1:0]    tx_len_o,
  input  logic             tx_ack_i,
  output logic             tx_done_o
);
  logic [DW-1:0] cmd, isr, imr, tsr;
  logic [DW-1:0] p0_q [N_OFS];
  logic [DW-1:0] p1_q [N_OFS];
  page_e         pg;
  logic          cmd_we, tx_fire, dma_done, isr_clr_we, imr_we;
  logic [EVT_W-1:0] isr_set;

  assign pg         = page_e'(cmd[PG_LSB +: 2]);
  assign cmd_we     = we_i && (addr_i == '0);
  assign isr_clr_we = we_i && (pg == PG_0) && (addr_i == OFS_W'(7));
  assign imr_we     = we_i && (pg == PG_0) && (addr_i == OFS_W'(15));
  assign dma_done   = cmd_we && (wdata_i[DMA_LSB +: DMA_W] != '0) && ({p0_q[11], p0_q[10]} == '0);

  always_comb begin
    isr_set = evt_i;
    if (tx_fire)  isr_set[ISR_TX]  = 1'b1;
    if (dma_done) isr_set[ISR_DMA] = 1'b1;
  end

  nic_cmd_ctrl u_cmd (
    .clk_i, .rst_ni,
    .we_i     (cmd_we),
    .wdata_i,
    .tx_ack_i,
    .cmd_o    (cmd),
    .tx_req_o,
    .tx_fire_o(tx_fire),
    .tx_done_o,
    .tsr_o    (tsr)
  );

  nic_irq_unit u_irq (
    .clk_i, .rst_ni,
    .set_i    (isr_set),
    .clr_we_i (isr_clr_we),
    .clr_i    (wdata_i[EVT_W-1:0]),
    .rs_clr_i (cmd_we && !wdata_i[CMD_STOP]),
    .imr_we_i (imr_we),
    .imr_i    (wdata_i),
    .isr_o    (isr),
    .imr_o    (imr),
    .irq_o
  );

  // page 0 setup bytes and page 1 address/filter bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int o = 0; o < N_OFS; o++) begin
        p0_q[o] <= '0;
        p1_q[o] <= '0;
      end
    end else if (we_i) begin
      for (int o = 1; o < N_OFS; o++) begin
        if (addr_i == OFS_W'(o)) begin
          if (pg == PG_0 && P0_WMASK[o]) p0_q[o] <= wdata_i;
          if (pg == PG_1)                p1_q[o] <= wdata_i;
        end
      end
    end
  end

  assign tx_addr_o = {p0_q[4], {DW{1'b0}}};
  assign tx_len_o  = {p0_q[6], p0_q[5]};

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o = cmd;
    else begin
      unique case (pg)
        PG_0: unique case (addr_i)
                4'd3, 4'd8, 4'd9: rdata_o = p0_q[addr_i];
                4'd4:             rdata_o = tsr;
                4'd7:             rdata_o = isr;
                default:          rdata_o = '0;
              endcase
        PG_1: rdata_o = p1_q[addr_i];
        PG_2: unique case (addr_i)
                4'd1, 4'd2, 4'd4, 4'd12, 4'd13, 4'd14: rdata_o = p0_q[addr_i];
                4'd15:   rdata_o = imr;
                default: rdata_o = '0;
              endcase
        default: rdata_o = '0;
      endcase
    end
  end

  AST_DMA_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done |=> isr[ISR_DMA]); // R7
  AST_STOP_CLEARS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && !wdata_i[CMD_STOP]) |=> !isr[ISR_RSTB]); // R6
  AST_PG3_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg == PG_3 && addr_i != '0) |-> (rdata_o == '0)); // R12
  AST_CMD_ALL_PAGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && !tx_req_o && !tx_ack_i) |=> (rdata_o == $past(wdata_i) || addr_i != '0)); // R2
endmodule

// File: tb/tb_nic_regfile.sv
module tb_nic_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        we_i = 1'b0, tx_ack_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0, rdata_o;
  logic [6:0]  evt_i = '0;
  logic        irq_o, tx_req_o, tx_done_o;
  logic [15:0] tx_addr_o, tx_len_o;

  nic_regfile dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int vecs = 0, errs = 0;
  bit finished = 1'b0;
  string cur = "R1";

  // reference model
  logic [7:0] m0 [16];
  logic [7:0] m1 [16];
  logic [7:0] mcmd = 8'h22, misr = 8'h80, mimr = 8'h00, mtsr = 8'h00;
  logic       mdone = 1'b0;

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    int p = mcmd[7:6];
    if (a == 0) return mcmd;
    if (p == 0) begin
      if (a == 3 || a == 8 || a == 9) return m0[a];
      if (a == 4) return mtsr;
      if (a == 7) return misr;
      return 8'h00;
    end
    if (p == 1) return m1[a];
    if (p == 2) begin
      if (a == 1 || a == 2 || a == 4 || a == 12 || a == 13 || a == 14) return m0[a];
      if (a == 15) return mimr;
      return 8'h00;
    end
    return 8'h00;
  endfunction

  task automatic step(input logic w, input logic [3:0] a, input logic [7:0] d,
                      input logic [6:0] e = 7'h0, input logic k = 1'b0);
    logic [7:0] er, nisr, setv, clrv, ncmd;
    logic       ei, fire, cw, ntx;
    int p;
    we_i = w; addr_i = a; wdata_i = d; evt_i = e; tx_ack_i = k;
    #1;
    er = exp_rd(a);
    ei = |(misr & mimr & 8'h7F);
    vecs++;
    if (rdata_o !== er) begin errs++; $display("FAIL %s rdata off %0d: got %02h exp %02h", cur, a, rdata_o, er); end
    if (irq_o !== ei) begin errs++; $display("FAIL %s irq: got %b exp %b", cur, irq_o, ei); end
    if (tx_req_o !== mcmd[2]) begin errs++; $display("FAIL %s tx_req: got %b exp %b", cur, tx_req_o, mcmd[2]); end
    if (tx_done_o !== mdone) begin errs++; $display("FAIL %s tx_done: got %b exp %b", cur, tx_done_o, mdone); end
    if (mcmd[2] && (tx_addr_o !== {m0[4], 8'h00} || tx_len_o !== {m0[6], m0[5]})) begin
      errs++; $display("FAIL %s tx addr/len: got %04h/%04h exp %04h/%04h", cur, tx_addr_o, tx_len_o, {m0[4], 8'h00}, {m0[6], m0[5]});
    end
    @(posedge clk_i);
    p = mcmd[7:6];
    fire = mcmd[2] && k;
    cw = w && a == 0;
    setv = {1'b0, e};
    if (fire) setv[1] = 1'b1;
    if (cw && d[5:3] != 0 && m0[11] == 0 && m0[10] == 0) setv[6] = 1'b1;
    clrv = (w && p == 0 && a == 7) ? (d & 8'h7F) : 8'h00;
    nisr = (misr & ~clrv) | setv;
    if (cw && !d[0]) nisr[7] = 1'b0;
    ntx = (mcmd[2] && !k) || (cw && d[2] && !mcmd[2]);
    ncmd = cw ? d : mcmd;
    ncmd[2] = ntx;
    if (w && a != 0) begin
      if (p == 0) begin
        if (a == 15) mimr = d;
        else if (a != 7) m0[a] = d;
      end else if (p == 1) m1[a] = d;
    end
    if (fire) mtsr = 8'h01;
    mdone = fire;
    misr = nisr;
    mcmd = ncmd;
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [3:0] a); step(1'b0, a, 8'h00); endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d); step(1'b1, a, d); endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m0[i] = 8'h00; m1[i] = 8'h00; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cur = "R1";  rd(0); rd(7); rd(15); rd(4);
    cur = "R11"; // page 0 setup, read back on page 2
    wr(1, 8'h40); wr(2, 8'h80); wr(3, 8'h4C); wr(4, 8'h50);
    wr(12, 8'h04); wr(13, 8'h02); wr(14, 8'h48); wr(15, 8'h00);
    wr(0, 8'hA1);
    for (int o = 1; o < 16; o++) rd(4'(o));
    wr(1, 8'hEE); rd(1); // page 2 write ignored
    cur = "R2";  wr(0, 8'h61); rd(0); rd(3);
    cur = "R10";
    for (int o = 1; o < 16; o++) wr(4'(o), 8'(8'h10 + o));
    for (int o = 1; o < 16; o++) rd(4'(o));
    cur = "R12"; wr(0, 8'hE1); wr(3, 8'h99); wr(9, 8'h77); rd(3); rd(9); rd(0);
    wr(0, 8'h21); rd(1); rd(3); rd(9); rd(10);
    cur = "R4";  wr(7, 8'h7F); rd(7);
    cur = "R3";  wr(15, 8'h80); rd(7);
    cur = "R5";  step(1'b0, 7, 8'h00, 7'h01); rd(7);
    for (int b = 0; b < 7; b++) step(1'b0, 7, 8'h00, 7'(1 << b));
    rd(7);
    cur = "R3";  wr(15, 8'h01); rd(7); wr(15, 8'h7F); rd(7);
    cur = "R4";  wr(7, 8'hFF); rd(7); step(1'b1, 7, 8'h04, 7'h04); rd(7); wr(7, 8'h04); rd(7);
    cur = "R6";  wr(0, 8'h21); rd(7); wr(0, 8'h20); rd(7);
    cur = "R7";  wr(7, 8'h7F); wr(10, 8'h05); wr(0, 8'h22); rd(7);
    wr(10, 8'h00); wr(11, 8'h01); wr(0, 8'h0A); rd(7);
    wr(11, 8'h00); wr(0, 8'h0A); rd(7);
    cur = "R8";  wr(7, 8'h7F); wr(15, 8'h02);
    wr(4, 8'h46); wr(5, 8'h3C); wr(6, 8'h01); wr(0, 8'h06);
    rd(0); rd(4); wr(0, 8'h02); rd(0); rd(7);
    cur = "R9";  step(1'b0, 0, 8'h00, 7'h0, 1'b1); rd(4); rd(7); rd(0); rd(0);
    cur = "R8";  wr(7, 8'h02); wr(5, 8'h40); wr(6, 8'h00); wr(4, 8'h60); wr(0, 8'h04); rd(0);
    cur = "R9";  step(1'b0, 7, 8'h00, 7'h0, 1'b1); rd(7); step(1'b0, 0, 8'h00, 7'h0, 1'b1); rd(0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule